// File: doc/BRIEF.md
# Registered Sixteen-Bit Eight-Function ALU

This block is the arithmetic and logic stage of a small 16-bit datapath. Each cycle it takes two 16-bit operands and a 3-bit function select. It computes one of eight results: sum, difference, low product, signed quotient, logical shift left, logical shift right, bitwise NOR, or signed less-than. The result is presented one clock later from a register. A divide-by-zero flag is registered alongside the result.

The divider is a fully unrolled restoring array built inside the block. It works on operand magnitudes and fixes the sign afterwards, so a quotient is ready in the same cycle as any other result. When the divisor is zero, the block only reports the condition. It never stops, and the reaction is left to the surrounding logic.

Top module: `alu16_core`

## Requirements
- R1: Select 000 yields (A + B) mod 2^16 and select 001 yields (A - B) mod 2^16; there is no carry or borrow output.
- R2: Select 010 yields the low 16 bits of the product A * B.
- R3: Select 011 yields the signed quotient A / B truncated toward zero; -32768 divided by -1 yields 16'h8000.
- R4: With select 011 and B equal to zero, the flag goes to 1 and the result is 16'h0000; for any other select, or a non-zero divisor, the flag is 0.
- R5: The shift selects (100 left, 101 right) shift A by B[3:0] only, so bits B[15:4] have no effect and an amount of 16 acts as 0.
- R6: Both shifts fill vacated bit positions with zeros, so a right shift never copies the sign bit.
- R7: Select 110 yields the bitwise complement of (A OR B).
- R8: Select 111 yields 16'h0001 when A is less than B as two's-complement numbers, and 16'h0000 otherwise.
- R9: Inputs sampled at one rising edge appear on the outputs after that edge (one-cycle latency); a synchronous active-high reset clears the result to 0 and the flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Function select |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand (divisor, shift amount source) |
| result_o | output | 16 | Registered result |
| div_zero_o | output | 1 | Registered divide-by-zero flag |

## Verification
Every output register is loaded from fresh inputs each cycle. A wrong mux select, a broken divider row or a bad shifter stage therefore shows on result_o in the very cycle after the offending operands are applied, and it cannot linger past the next cycle. A sign-fix error in the divider shows only for operands of mixed sign or at the most negative value. A mask error in the shift amount shows only when B has bits set above bit 3. For this reason the stimulus aims at these operand classes directly, and it also sweeps broadly across all selects.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    FN_ADD = 3'b000,
    FN_SUB = 3'b001,
    FN_MUL = 3'b010,
    FN_DIV = 3'b011,
    FN_SHL = 3'b100,
    FN_SHR = 3'b101,
    FN_NOR = 3'b110,
    FN_SLT = 3'b111
  } alu_fn_e;
endpackage

// File: rtl/alu16_shifter.sv
// Logarithmic logical shifter; zero fill in both directions.
module alu16_shifter #(
  parameter int unsigned W = 16,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] amt_i,
  input  logic          right_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] stage [0:SW];

  assign stage[0] = val_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    logic [W-1:0] moved;
    assign moved = right_i ? (stage[k] >> (2**k)) : (stage[k] << (2**k));
    assign stage[k+1] = amt_i[k] ? moved : stage[k];
  end

  assign res_o = stage[SW];
endmodule

// File: rtl/alu16_divider.sv
// Signed combinational divider: magnitudes through an unrolled restoring array.
module alu16_divider #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic         zero_o
);
  logic [W-1:0] mag_n, mag_d, mag_q;
  logic         neg_q;

  assign mag_n  = num_i[W-1] ? (~num_i + 1'b1) : num_i;
  assign mag_d  = den_i[W-1] ? (~den_i + 1'b1) : den_i;
  assign neg_q  = num_i[W-1] ^ den_i[W-1];
  assign zero_o = (den_i == '0);

  // partial remainder entering each row; row index counts down from the MSB
  logic [W-1:0] rem [0:W];
  assign rem[W] = '0;

  for (genvar j = W - 1; j >= 0; j--) begin : g_row
    logic [W:0] trial;
    logic       fits;
    logic [W:0] diff;
    assign trial     = {rem[j+1], mag_n[j]};
    assign fits      = (trial >= {1'b0, mag_d});
    assign diff      = trial - {1'b0, mag_d};
    assign mag_q[j]  = fits;
    assign rem[j]    = fits ? diff[W-1:0] : trial[W-1:0];
  end

  assign quo_o = neg_q ? (~mag_q + 1'b1) : mag_q;
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int unsigned W = 16,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic [W-1:0]     result_o,
  output logic             div_zero_o
);
  alu_fn_e      fn;
  logic [W-1:0] sum, dif, prod, quo, shl, shr, nor_v, slt_v;
  logic         den_zero;
  logic [W-1:0] res_d;
  logic         dz_d;

  assign fn = alu_fn_e'(op_i);

  assign sum   = a_i + b_i;
  assign dif   = a_i - b_i;
  assign prod  = a_i * b_i;
  assign nor_v = ~(a_i | b_i);
  assign slt_v = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};

  alu16_divider #(.W(W)) u_div (
    .num_i  (a_i),
    .den_i  (b_i),
    .quo_o  (quo),
    .zero_o (den_zero)
  );

  alu16_shifter #(.W(W)) u_shl (
    .val_i   (a_i),
    .amt_i   (b_i[SW-1:0]),
    .right_i (1'b0),
    .res_o   (shl)
  );

  alu16_shifter #(.W(W)) u_shr (
    .val_i   (a_i),
    .amt_i   (b_i[SW-1:0]),
    .right_i (1'b1),
    .res_o   (shr)
  );

  always_comb begin
    dz_d = 1'b0;
    unique case (fn)
      FN_ADD: res_d = sum;
      FN_SUB: res_d = dif;
      FN_MUL: res_d = prod;
      FN_DIV: begin
        dz_d  = den_zero;
        res_d = den_zero ? '0 : quo;
      end
      FN_SHL: res_d = shl;
      FN_SHR: res_d = shr;
      FN_NOR: res_d = nor_v;
      FN_SLT: res_d = slt_v;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o   <= '0;
      div_zero_o <= 1'b0;
    end else begin
      result_o   <= res_d;
      div_zero_o <= dz_d;
    end
  end
endmodule

// File: rtl/alu16_core_checker.sv
module alu16_core_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o,
  input logic         div_zero_o
);
  // R9: reset clears both outputs on the following edge
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !div_zero_o));

  // R4: zero divisor raises the flag and zeroes the result
  assert_div_zero_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b011 && b_i == '0) |=> (div_zero_o && result_o == '0));

  // R4: flag stays low for every other select
  assert_no_flag_other_R4: assert property (@(posedge clk) disable iff (rst)
    (op_i != 3'b011) |=> !div_zero_o);

  // R4: flag stays low for a non-zero divisor
  assert_no_flag_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (b_i != '0) |=> !div_zero_o);

  // R8: compare result is 0 or 1 only
  assert_slt_bool_R8: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b111) |=> (result_o[W-1:1] == '0));

  // R5: shift amount with zero low nibble leaves A unchanged
  assert_shift_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    ((op_i == 3'b100 || op_i == 3'b101) && b_i[3:0] == 4'd0) |=> (result_o == $past(a_i)));

  // R6: right shift by a non-zero amount clears the top bit
  assert_shr_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b101 && b_i[3:0] != 4'd0) |=> !result_o[W-1]);

  // R6: left shift by a non-zero amount clears bit 0
  assert_shl_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b100 && b_i[3:0] != 4'd0) |=> !result_o[0]);

  // R3: dividing by one returns the dividend
  assert_div_by_one_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b011 && b_i == 16'd1) |=> (result_o == $past(a_i)));
endmodule

bind alu16_core alu16_core_checker #(.W(W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .op_i       (op_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .result_o   (result_o),
  .div_zero_o (div_zero_o)
);

// File: tb/test_alu16_core.sv
module test_alu16_core;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op_i = '0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] result_o;
  logic         div_zero_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [W-1:0] res;
    logic         dz;
    string        tag;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_core i_alu16_core (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .div_zero_o(div_zero_o)
  );

  function automatic exp_t model(input logic [2:0] op, input logic [W-1:0] a,
                                 input logic [W-1:0] b);
    exp_t e;
    int sa, sb, qv;
    int sh;
    sa = $signed(a);
    sb = $signed(b);
    sh = int'(b % 16);
    e.dz = 1'b0;
    case (op)
      3'd0: begin e.res = W'(a + b);       e.tag = "R1"; end
      3'd1: begin e.res = W'(a - b);       e.tag = "R1"; end
      3'd2: begin e.res = W'(int'(a) * int'(b)); e.tag = "R2"; end
      3'd3: begin
        if (b == 0) begin e.res = '0; e.dz = 1'b1; e.tag = "R4"; end
        else begin qv = sa / sb; e.res = W'(qv); e.tag = "R3"; end
      end
      3'd4: begin e.res = W'(int'(a) * (1 << sh)); e.tag = "R5"; end
      3'd5: begin e.res = W'(int'(a) / (1 << sh)); e.tag = "R6"; end
      3'd6: begin e.res = a ^ 16'hFFFF ^ (b & ~a); e.tag = "R7"; end
      default: begin e.res = (sa < sb) ? 16'd1 : 16'd0; e.tag = "R8"; end
    endcase
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    #1;
    op_i = op; a_i = a; b_i = b;
    q.push_back(model(op, a, b));
  endtask

  // monitor: each item is due at the negedge after the edge that captured it
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (result_o !== e.res || div_zero_o !== e.dz) begin
          n_fail++;
          $display("FAIL %s: result=%h flag=%b expected result=%h flag=%b",
                   e.tag, result_o, div_zero_o, e.res, e.dz);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R9: reset holds outputs at zero even with active-looking inputs
    op_i = 3'd0; a_i = 16'h1234; b_i = 16'h1111;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (result_o !== '0 || div_zero_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: result=%h flag=%b expected result=0000 flag=0", result_o, div_zero_o);
    end
    #1 rst = 1'b0;

    // R1 wrap
    drive(3'd0, 16'hFFFF, 16'h0002);
    drive(3'd1, 16'h0000, 16'h0001);
    drive(3'd0, 16'h1234, 16'h4321);
    // R2 low product
    drive(3'd2, 16'h0100, 16'h0100);
    drive(3'd2, 16'hFFFF, 16'hFFFF);
    drive(3'd2, 16'd300, 16'd7);
    // R3 signed division, truncation toward zero
    drive(3'd3, 16'd7, 16'hFFFE);
    drive(3'hB & 3'd3, 16'hFFF9, 16'd2);
    drive(3'd3, 16'h8000, 16'hFFFF);
    drive(3'd3, 16'd100, 16'd7);
    drive(3'd3, 16'h8000, 16'h8000);
    drive(3'd3, 16'd5, 16'd9);
    // R4 zero divisor, and no flag with zero B on other selects
    drive(3'd3, 16'h7FFF, 16'h0000);
    drive(3'd0, 16'h0005, 16'h0000);
    drive(3'd3, 16'h0000, 16'h0000);
    // R5 masking of the amount: 16 and 0x0013 act as 0 and 3
    drive(3'd4, 16'h00A5, 16'h0010);
    drive(3'd4, 16'h00A5, 16'h0013);
    drive(3'd4, 16'h0001, 16'h000F);
    drive(3'd5, 16'hA500, 16'hFFF4);
    // R6 zero fill on right shift of a negative value
    drive(3'd5, 16'h8000, 16'h0001);
    drive(3'd5, 16'hFFFF, 16'h000F);
    // R7 NOR
    drive(3'd6, 16'h0000, 16'h0000);
    drive(3'd6, 16'hF0F0, 16'h0FF0);
    // R8 signed compare
    drive(3'd7, 16'hFFFF, 16'h0001);
    drive(3'd7, 16'h0001, 16'hFFFF);
    drive(3'd7, 16'h1234, 16'h1234);
    drive(3'd7, 16'h8000, 16'h7FFF);

    // broad sweep over all selects
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      if (i % 10 == 0) rb = '0;
      if (i % 13 == 0) ra = 16'h8000;
      drive(3'(i % 8), ra, rb);
    end

    // mid-stream synchronous reset clears outputs (R9)
    @(negedge clk);
    #1 rst = 1'b1;
    op_i = 3'd6; a_i = '0; b_i = '0;
    @(negedge clk);
    n_checks++;
    if (result_o !== '0 || div_zero_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: result=%h flag=%b expected result=0000 flag=0", result_o, div_zero_o);
    end
    q.delete();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule